// File: doc/BRIEF.md
# Sampling Converter Conversion Sequencer

This block sits on the host side of a 16-bit successive-approximation sampling converter and runs its conversion cycle. It makes the acquire command (SAMPLE) by dividing the system clock by a power of two. It makes a gated conversion clock that stays low while the converter acquires its input, and runs only after the converter reports that it is busy. It takes the parallel result when the busy indication drops, and hands it to the host as a registered word with a one-cycle valid strobe. The host can take that word as two's complement or as offset binary.

The busy input is asynchronous, so it passes through a two-stage synchronizer before any edge is detected. The conversion clock divider is held cleared for as long as the synchronized busy is low. So no clock edge reaches the converter during acquisition, and the last clock pulse of a conversion is cut short as soon as busy drops. In continuous operation, SAMPLE may already be high when a conversion ends. In that case a new acquisition window opens at once, and the watchdog restarts its count from that moment.

The watchdog measures each conversion window from the start of acquisition and raises an error flag when the window runs too long. There is no limit on the idle time between windows. A sticky overrun flag records that a result arrived before the host had taken the previous one.

Top module: `adc_seq_top`

## Requirements
- R1: Each conversion gets exactly 17 rising edges on `conv_clk_out`, and no further rising edge occurs until the converter raises busy again.
- R2: `conv_clk_out` is low whenever the twice-synchronized busy is low. Once busy is seen high, the clock toggles every CONV_DIV/2 system cycles, starting low, so its high and low phases are equal.
- R3: When the synchronized busy falls, `conv_clk_out` is low after the next edge, even if that cuts the current high phase short.
- R4: The result is captured in the cycle in which the synchronized busy falls. `data_valid` and `data_out` appear after the second clock edge following the edge that first samples `busy_in` low. With `offset_bin`=0 the word is passed as is (two's complement). With `offset_bin`=1, bit 15 is inverted, so 0x7FFF becomes 0xFFFF and 0x8000 becomes 0x0000.
- R5: `data_valid` is high for exactly one cycle per result. `data_out` holds its value until the next result.
- R6: `overrun` is set when a new result is captured while the previous one is still unacknowledged, and it stays set until reset. If `data_ack` is high in the capture cycle, the previous result counts as acknowledged.
- R7: `timeout_err` is set once a conversion window has been open for TIMEOUT_CYCLES system cycles without busy falling. A window opens on a SAMPLE rise while no window is open, or at a busy fall while SAMPLE is high. `timeout_err` clears when the next window opens.
- R8: `sample_out` is a 50 % square wave with a period of 2^(SAMPLE_LOG2-1) system cycles when `rate_sel`=0 and 2^SAMPLE_LOG2 when `rate_sel`=1, counted from reset.
- R9: `sample_out` never changes in the same cycle in which `conv_clk_out` rises. Such a change is delayed by one cycle.
- R10: A SAMPLE rise while a conversion window is already open neither restarts the watchdog count nor clears `timeout_err`.
- R11: During reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 1 | 0: fast SAMPLE rate, 1: half that rate |
| offset_bin | input | 1 | 0: two's complement output, 1: offset binary |
| busy_in | input | 1 | Busy indication from the converter (asynchronous) |
| adc_data_in | input | 16 | Parallel result from the converter |
| data_ack | input | 1 | Host acknowledges the held result |
| sample_out | output | 1 | Acquire command to the converter |
| conv_clk_out | output | 1 | Gated conversion clock |
| data_out | output | 16 | Captured, formatted result |
| data_valid | output | 1 | One-cycle strobe for a new result |
| overrun | output | 1 | Sticky: a result was captured before the previous one was acknowledged |
| timeout_err | output | 1 | Conversion window exceeded its limit |

## Verification
Two pairs of functions can land on the same cycle. The first pair is the host acknowledge and the capture of a new result. The bench provokes this by raising `data_ack` exactly in the cycle its model predicts the busy fall, and judges it by `overrun` staying low while two results are taken back to back. The second pair is the end of a conversion and the opening of the next window. With the slower SAMPLE rate, SAMPLE is already high when busy falls. The cycle-by-cycle model then expects the watchdog to restart in that same cycle, and also expects the conversion clock to stay stopped and SAMPLE to be held back whenever a clock rise and a SAMPLE edge coincide.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    // rising conversion-clock edges in one conversion
    localparam int CONV_EDGES = 17;

    typedef enum logic {
        FMT_TWOS   = 1'b0,
        FMT_OFFSET = 1'b1
    } fmt_e;
endpackage

// File: rtl/adc_seq_sample_gen.sv
module adc_seq_sample_gen #(
    parameter int SAMPLE_LOG2 = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_sel,
    input  logic hold_edge,
    output logic sample_o,
    output logic rise_next_o
);
    localparam int CW = SAMPLE_LOG2;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          smp;
    } st_t;

    st_t st_d, st_q;
    logic want;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
        want     = rate_sel ? st_q.cnt[CW-1] : st_q.cnt[CW-2];
        // keep the SAMPLE edge away from a conversion-clock rise
        st_d.smp = hold_edge ? st_q.smp : want;
        rise_next_o = st_d.smp & ~st_q.smp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample_o = st_q.smp;
endmodule

// File: rtl/adc_seq_conv_clk.sv
module adc_seq_conv_clk #(
    parameter int HALF  = 4,
    parameter int EDGES = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic clk_o,
    output logic rise_next_o
);
    localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int RW = $clog2(EDGES + 2);

    typedef struct packed {
        logic [HW-1:0] ph;
        logic          cc;
        logic [RW-1:0] rises;
    } st_t;

    st_t st_d, st_q;
    logic wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.ph == HW'(HALF - 1));
        rise_next_o = run & wrap & ~st_q.cc;
        if (!run) begin
            // divider held cleared: stopped during acquisition, truncated at end
            st_d = '0;
        end else if (wrap) begin
            st_d.ph = '0;
            st_d.cc = ~st_q.cc;
            if (!st_q.cc) st_d.rises = st_q.rises + 1'b1;
        end else begin
            st_d.ph = st_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clk_o = st_q.cc;

    AST_RISE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rises <= RW'(EDGES)) else $error("rise count above limit"); // R1
    AST_CLK_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !st_q.cc) else $error("clock ran while idle"); // R2
endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              fmt,
    input  logic [DATA_W-1:0] din,
    input  logic              ack,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              ovr_o
);
    import adc_seq_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              pend;
        logic              ovr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = capture;
        if (capture) begin
            st_d.data = din;
            if (fmt_e'(fmt) == FMT_OFFSET) st_d.data[DATA_W-1] = ~din[DATA_W-1];
        end
        st_d.ovr  = st_q.ovr | (capture & st_q.pend & ~ack);
        st_d.pend = capture | (st_q.pend & ~ack);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o  = st_q.data;
    assign valid_o = st_q.valid;
    assign ovr_o   = st_q.ovr;

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid) else $error("valid longer than one cycle"); // R5
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovr |=> st_q.ovr) else $error("overrun cleared"); // R6
endmodule

// File: rtl/adc_seq_watchdog.sv
module adc_seq_watchdog #(
    parameter int LIMIT = 12288
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp,
    input  logic smp_rise_next,
    input  logic done,
    output logic tmo_o
);
    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic          win;
        logic [CW-1:0] cnt;
        logic          tmo;
    } st_t;

    st_t st_d, st_q;
    logic open_w;

    always_comb begin
        st_d   = st_q;
        // new window: fresh SAMPLE rise, or conversion ends with SAMPLE high
        open_w = (smp_rise_next & ~st_q.win) | (done & smp);
        if (open_w) begin
            st_d.win = 1'b1;
            st_d.cnt = '0;
            st_d.tmo = 1'b0;
        end else begin
            if (st_q.win && st_q.cnt == CW'(LIMIT - 1)) st_d.tmo = 1'b1;
            if (st_q.win && st_q.cnt < CW'(LIMIT)) st_d.cnt = st_q.cnt + 1'b1;
            if (done) st_d.win = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tmo_o = st_q.tmo;

    AST_TMO_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.tmo) |-> $past(st_q.win)) else $error("timeout outside window"); // R7
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
    parameter int DATA_W         = 16,
    parameter int SAMPLE_LOG2    = 8,
    parameter int CONV_DIV       = 8,
    parameter int TIMEOUT_CYCLES = 12288
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_sel,
    input  logic              offset_bin,
    input  logic              busy_in,
    input  logic [DATA_W-1:0] adc_data_in,
    input  logic              data_ack,
    output logic              sample_out,
    output logic              conv_clk_out,
    output logic [DATA_W-1:0] data_out,
    output logic              data_valid,
    output logic              overrun,
    output logic              timeout_err
);
    import adc_seq_pkg::*;

    localparam int HALF = CONV_DIV / 2;

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t sy_d, sy_q;
    logic busy_run, busy_fall, cc_rise_next, smp_rise_next;

    always_comb begin
        sy_d.s1 = busy_in;
        sy_d.s2 = sy_q.s1;
        sy_d.s3 = sy_q.s2;
        busy_run  = sy_q.s2;
        busy_fall = sy_q.s3 & ~sy_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    adc_seq_sample_gen #(.SAMPLE_LOG2(SAMPLE_LOG2)) u_sample (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .hold_edge(cc_rise_next),
        .sample_o(sample_out), .rise_next_o(smp_rise_next));

    adc_seq_conv_clk #(.HALF(HALF), .EDGES(CONV_EDGES)) u_cclk (
        .clk(clk), .rst_n(rst_n), .run(busy_run),
        .clk_o(conv_clk_out), .rise_next_o(cc_rise_next));

    adc_seq_result #(.DATA_W(DATA_W)) u_result (
        .clk(clk), .rst_n(rst_n), .capture(busy_fall), .fmt(offset_bin),
        .din(adc_data_in), .ack(data_ack),
        .data_o(data_out), .valid_o(data_valid), .ovr_o(overrun));

    adc_seq_watchdog #(.LIMIT(TIMEOUT_CYCLES)) u_wdog (
        .clk(clk), .rst_n(rst_n), .smp(sample_out), .smp_rise_next(smp_rise_next),
        .done(busy_fall), .tmo_o(timeout_err));

    AST_SAMPLE_CLEAR_OF_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_clk_out) |-> $stable(sample_out)) else $error("SAMPLE moved on clock rise"); // R9
endmodule

// File: tb/test_adc_seq_top.sv
module test_adc_seq_top;
    localparam int W     = 16;
    localparam int HALF  = 4;
    localparam int LIMIT = 12288;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, rate_sel = 1'b0, offset_bin = 1'b0, busy_in = 1'b0, data_ack = 1'b0;
    logic [W-1:0] adc_data_in = '0;
    logic sample_out, conv_clk_out, data_valid, overrun, timeout_err;
    logic [W-1:0] data_out;

    adc_seq_top #(.DATA_W(W), .SAMPLE_LOG2(8), .CONV_DIV(2*HALF), .TIMEOUT_CYCLES(LIMIT)) i_adc_seq_top (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .offset_bin(offset_bin),
        .busy_in(busy_in), .adc_data_in(adc_data_in), .data_ack(data_ack),
        .sample_out(sample_out), .conv_clk_out(conv_clk_out), .data_out(data_out),
        .data_valid(data_valid), .overrun(overrun), .timeout_err(timeout_err));

    int checks = 0, fails = 0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [2:0]   bhist;      // busy_in seen at the last three edges, [0] newest
    int           busy_run_n; // consecutive cycles the settled busy has been high
    logic [7:0]   tick;
    logic         e_cc, e_samp, e_valid, e_ovr, e_tmo, e_win, e_pend, fall_next;
    logic [W-1:0] e_data;
    int           wd;

    always @(posedge clk) begin : ref_model
        logic oc, os, fall, want;
        if (!rst_n) begin
            bhist = '0; busy_run_n = 0; tick = '0; wd = 0;
            e_cc = 0; e_samp = 0; e_valid = 0; e_ovr = 0; e_tmo = 0;
            e_win = 0; e_pend = 0; e_data = '0; fall_next = 0;
        end else begin
            oc = e_cc; os = e_samp;
            fall = bhist[2] & ~bhist[1];
            if (bhist[1]) busy_run_n++; else busy_run_n = 0;
            e_cc = ((busy_run_n / HALF) % 2) == 1;
            want = rate_sel ? tick[7] : tick[6];
            e_samp = (e_cc && !oc) ? os : want;
            tick++;
            e_valid = fall;
            if (fall) e_data = adc_data_in ^ {offset_bin, {(W-1){1'b0}}};
            if (fall && e_pend && !data_ack) e_ovr = 1;
            e_pend = fall | (e_pend & ~data_ack);
            if ((e_samp && !os && !e_win) || (fall && os)) begin
                e_win = 1; wd = 0; e_tmo = 0;
            end else begin
                if (e_win && wd == LIMIT - 1) e_tmo = 1;
                if (e_win && wd < LIMIT) wd++;
                if (fall) e_win = 0;
            end
            bhist = {bhist[1:0], busy_in};
            fall_next = bhist[2] & ~bhist[1];
        end
    end

    // ---------------- converter model, host ack, per-cycle compare ----------------
    int   ack_mode = 0;   // 0 ack on valid, 1 ack exactly at capture, 2 never
    logic stall = 0;
    logic cv_busy = 0, prev_s = 0, prev_c = 0, have_prev = 0;
    int   start_wait = 0, drop_wait = 0, cv_edges = 0, ep_rises = 0, code_i = 0, conv_done = 0;
    logic [W-1:0] codes [6] = '{16'h7FFF, 16'h8000, 16'h0000, 16'hFFFF, 16'h0001, 16'h1234};

    always @(negedge clk) begin
        if (!rst_n) begin
            cv_busy = 0; busy_in = 0; start_wait = 0; drop_wait = 0; cv_edges = 0;
            ep_rises = 0; have_prev = 0; prev_s = 0; prev_c = 0; data_ack = 0;
        end else begin
            chk("R8 R9 sample_out", sample_out, e_samp);
            chk("R1 R2 R3 conv_clk_out", conv_clk_out, e_cc);
            chk("R5 data_valid", data_valid, e_valid);
            chk("R4 data_out", data_out, e_data);
            chk("R6 overrun", overrun, e_ovr);
            chk("R7 R10 timeout_err", timeout_err, e_tmo);
            if (conv_clk_out && !prev_c) ep_rises++;
            if (cv_busy && conv_clk_out && !prev_c) begin
                cv_edges++;
                if (cv_edges == 17) drop_wait = 2;
            end
            if (drop_wait > 0) begin
                drop_wait--;
                if (drop_wait == 0) begin busy_in = 0; cv_busy = 0; conv_done++; end
            end
            if (!cv_busy && start_wait == 0 && prev_s && !sample_out && !stall) start_wait = 3;
            if (start_wait > 0) begin
                start_wait--;
                if (start_wait == 0) begin
                    if (have_prev) chk("R1 rises per conversion", ep_rises, 17);
                    ep_rises = 0; have_prev = 1;
                    cv_busy = 1; busy_in = 1; cv_edges = 0;
                    adc_data_in = codes[code_i]; code_i = (code_i + 1) % 6;
                end
            end
            case (ack_mode)
                0: data_ack = data_valid;
                1: data_ack = fall_next;
                default: data_ack = 0;
            endcase
            prev_s = sample_out; prev_c = conv_clk_out;
        end
    end

    task automatic wait_conv(input int n);
        int base;
        base = conv_done;
        while (conv_done < base + n) @(negedge clk);
    endtask

    task automatic check_reset_state();
        chk("R11 sample_out in reset", sample_out, 0);
        chk("R11 conv_clk_out in reset", conv_clk_out, 0);
        chk("R11 data_out in reset", data_out, 0);
        chk("R11 data_valid in reset", data_valid, 0);
        chk("R11 overrun in reset", overrun, 0);
        chk("R11 timeout_err in reset", timeout_err, 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check_reset_state();
        rst_n = 1;
        wait_conv(6);                       // R4 two's complement, fast rate
        offset_bin = 1;
        wait_conv(6);                       // R4 offset binary incl. 0x7FFF and 0x8000
        rate_sel = 1; ack_mode = 1;
        wait_conv(4);                       // R6 ack in capture cycle, R7 restart at busy fall
        chk("R6 ack coincident with capture", overrun, 0);
        ack_mode = 2;
        wait_conv(3);
        chk("R6 overrun after unacked result", overrun, 1);
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        check_reset_state();
        stall = 1; ack_mode = 0; rst_n = 1;
        repeat (LIMIT + 300) @(negedge clk);
        chk("R7 timeout on stalled conversion", timeout_err, 1);
        stall = 0;
        wait_conv(3);
        repeat (4) @(negedge clk);
        chk("R7 timeout cleared by new window", timeout_err, 0);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule